// File: doc/BRIEF.md
# Cascaded Display RAM Write Loader

The block takes display data bytes one at a time and writes them into a display memory of 24 addresses by 4 rows. The multiplex drive mode decides how the bits of a byte are packed. In static mode each address takes one bit. In two-way mode each address takes two bits. In three-way mode each address takes three bits. In four-way mode each address takes four bits. The bits are taken most significant first and fill the rows of one address before moving on to the next address. A 5-bit data pointer selects the address. It steps forward by one for each address touched, and after address 23 it returns to 0.

Several copies of the block can share one byte stream in a cascade. Each copy holds a 3-bit subaddress counter and compares it with its own 3-bit strap inputs. Only the copy whose counter matches the strap drives its RAM write enable. Every copy still advances its pointer. When the pointer wraps past the last address, the counter moves on to the next device. This can happen partway through a byte.

A byte takes one clock for each address it touches. The busy flag stays high for those clocks so that the upstream receiver can stretch its bus clock. The write port carries a row mask, so rows that a byte does not own keep their contents.

Top module: `disp_ram_loader`

## Requirements
- R1: After reset, busy_o and wr_en_o are low, and the data pointer and the subaddress counter are 0. A first byte, with no load and with strap 0, is written starting at address 0.
- R2: Static mode (mode_i = 2'b00) writes the byte to row 0 of 8 consecutive addresses. Bit 7 goes to the first address and bit 0 to the last. The mask is 4'b0001 (wr_mask_o bit r is row r).
- R3: Two-way mode (mode_i = 2'b01) writes 4 addresses. For each address, the higher of its two byte bits goes to row 0 and the lower to row 1. Bits 7 and 6 go to the first address.
- R4: Three-way mode (mode_i = 2'b10) writes 3 addresses, taking bits 7..5, 4..2 and 1..0 into rows 0, 1, 2 in order. Row 2 of the third address is masked off and keeps its old value.
- R5: Four-way mode (mode_i = 2'b11) writes 2 addresses. Bits 7..4 go to rows 0..3 of the first address and bits 3..0 to rows 0..3 of the second.
- R6: With bank_i = 1, static mode writes row 2 instead of row 0, and two-way mode writes rows 2 and 3 instead of rows 0 and 1. bank_i has no effect in three-way and four-way modes.
- R7: A byte is accepted on a clock edge when byte_valid_i is high and busy_o is low. busy_o is then high for exactly 8, 4, 3 or 2 cycles by mode, and one address is presented per cycle.
- R8: wr_en_o is high only while busy and only when the subaddress counter equals strap_i. The pointer advances whether or not the write is suppressed.
- R9: When the pointer passes address 23, it returns to 0 and the subaddress counter increments. This also happens in the middle of a byte, and the remaining bits then belong to the next subaddress.
- R10: byte_valid_i is ignored while busy_o is high.
- R11: ptr_load_i and sub_load_i take effect at an edge where busy_o is low. If byte_valid_i comes in the same cycle, the byte uses the loaded values. Both loads are ignored while busy.
- R12: A pointer load value above 23 loads address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| byte_i | input | 8 | Display data byte |
| byte_valid_i | input | 1 | Byte strobe |
| mode_i | input | 2 | Drive mode: 0 static, 1 two-way, 2 three-way, 3 four-way |
| bank_i | input | 1 | Alternate input bank select |
| ptr_load_i | input | 1 | Load data pointer strobe |
| ptr_val_i | input | 5 | Data pointer load value |
| sub_load_i | input | 1 | Load subaddress counter strobe |
| sub_val_i | input | 3 | Subaddress counter load value |
| strap_i | input | 3 | Hardware subaddress strap |
| busy_o | output | 1 | Byte in progress; upstream must stall |
| wr_en_o | output | 1 | RAM write enable |
| wr_addr_o | output | 5 | RAM write address |
| wr_mask_o | output | 4 | Row write mask |
| wr_data_o | output | 4 | Row write data |

## Verification
Two functions can fall in the same cycle. The first pair is a pointer or subaddress load together with the acceptance of a byte. The bench raises both strobes in one idle cycle and judges the result from the RAM image, which must show the byte placed at the loaded address under the loaded subaddress. The second pair is the pointer wrap together with a suppressed-to-enabled change of the write gate inside one three-way byte. The bench starts that byte at address 22 one subaddress below the strap, and expects only the bits that fall at address 0 to be stored. Loads and extra byte strobes raised during a busy byte are also provoked, and must leave the image and the busy length unchanged.

// File: rtl/dram_ld_pkg.sv
`timescale 1ns/1ps
package dram_ld_pkg;

  typedef enum logic [1:0] {
    MUX_STATIC = 2'd0,
    MUX_TWO    = 2'd1,
    MUX_THREE  = 2'd2,
    MUX_FOUR   = 2'd3
  } mux_mode_e;

  // rows written per address (= byte bits consumed per pointer step)
  function automatic logic [2:0] rows_per_addr(mux_mode_e m);
    case (m)
      MUX_STATIC: rows_per_addr = 3'd1;
      MUX_TWO:    rows_per_addr = 3'd2;
      MUX_THREE:  rows_per_addr = 3'd3;
      default:    rows_per_addr = 3'd4;
    endcase
  endfunction

  function automatic logic has_alt_bank(mux_mode_e m);
    has_alt_bank = (m == MUX_STATIC) || (m == MUX_TWO);
  endfunction

endpackage

// File: rtl/dram_ld_ptr.sv
`timescale 1ns/1ps
module dram_ld_ptr #(
  parameter int DEPTH = 24,
  parameter int PTR_W = 5,
  parameter int SUB_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             ld_ptr_i,
  input  logic [PTR_W-1:0] ptr_val_i,
  input  logic             ld_sub_i,
  input  logic [SUB_W-1:0] sub_val_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic [SUB_W-1:0] sub_o
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [PTR_W-1:0] LIM  = PTR_W'(DEPTH);

  logic [PTR_W-1:0] ptr_q;
  logic [SUB_W-1:0] sub_q;
  logic             wrap;

  assign wrap = (ptr_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      sub_q <= '0;
    end else if (adv_i) begin
      if (wrap) begin
        ptr_q <= '0;
        sub_q <= sub_q + 1'b1;
      end else begin
        ptr_q <= ptr_q + 1'b1;
      end
    end else begin
      if (ld_ptr_i) ptr_q <= (ptr_val_i < LIM) ? ptr_val_i : '0;
      if (ld_sub_i) sub_q <= sub_val_i;
    end
  end

  assign ptr_o = ptr_q;
  assign sub_o = sub_q;

endmodule

// File: rtl/dram_ld_seq.sv
`timescale 1ns/1ps
module dram_ld_seq
  import dram_ld_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ROWS   = 4,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  mux_mode_e         mode_i,
  input  logic              bank_i,
  output logic              busy_o,
  output logic [ROWS-1:0]   head_o,
  output logic [CNT_W-1:0]  take_o,
  output mux_mode_e         mode_o,
  output logic              bank_o
);

  logic              active_q;
  logic [BYTE_W-1:0] sh_q;
  logic [CNT_W-1:0]  rem_q;
  mux_mode_e         mode_q;
  logic              bank_q;
  logic [CNT_W-1:0]  step;
  logic [CNT_W-1:0]  take;

  assign step = CNT_W'(rows_per_addr(mode_q));
  // last address of a three-way byte only has the leftover bits
  assign take = (rem_q < step) ? rem_q : step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sh_q     <= '0;
      rem_q    <= '0;
      mode_q   <= MUX_FOUR;
      bank_q   <= 1'b0;
    end else if (active_q) begin
      sh_q  <= sh_q << step;
      rem_q <= rem_q - take;
      if (rem_q == take) active_q <= 1'b0;
    end else if (byte_valid_i) begin
      active_q <= 1'b1;
      sh_q     <= byte_i;
      rem_q    <= CNT_W'(BYTE_W);
      mode_q   <= mode_i;
      bank_q   <= bank_i;
    end
  end

  assign busy_o = active_q;
  assign head_o = sh_q[BYTE_W-1 -: ROWS];
  assign take_o = take;
  assign mode_o = mode_q;
  assign bank_o = bank_q;

endmodule

// File: rtl/dram_ld_pack.sv
`timescale 1ns/1ps
module dram_ld_pack
  import dram_ld_pkg::*;
#(
  parameter int ROWS  = 4,
  parameter int CNT_W = 4
) (
  input  logic [ROWS-1:0]  head_i,
  input  logic [CNT_W-1:0] take_i,
  input  mux_mode_e        mode_i,
  input  logic             bank_i,
  output logic [ROWS-1:0]  mask_o,
  output logic [ROWS-1:0]  data_o
);

  localparam int OFF = ROWS / 2;

  logic [ROWS-1:0] raw_mask;
  logic [ROWS-1:0] raw_data;
  logic            alt;

  // head_i[ROWS-1] is the next (most significant) unconsumed bit -> row 0
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign raw_mask[r] = (CNT_W'(r) < take_i);
    assign raw_data[r] = head_i[ROWS-1-r] & raw_mask[r];
  end

  assign alt    = bank_i & has_alt_bank(mode_i);
  assign mask_o = alt ? (raw_mask << OFF) : raw_mask;
  assign data_o = alt ? (raw_data << OFF) : raw_data;

endmodule

// File: rtl/disp_ram_loader.sv
`timescale 1ns/1ps
module disp_ram_loader
  import dram_ld_pkg::*;
#(
  parameter int DEPTH  = 24,
  parameter int ROWS   = 4,
  parameter int BYTE_W = 8,
  parameter int SUB_W  = 3,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(BYTE_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_valid_i,
  input  logic [1:0]        mode_i,
  input  logic              bank_i,
  input  logic              ptr_load_i,
  input  logic [PTR_W-1:0]  ptr_val_i,
  input  logic              sub_load_i,
  input  logic [SUB_W-1:0]  sub_val_i,
  input  logic [SUB_W-1:0]  strap_i,
  output logic              busy_o,
  output logic              wr_en_o,
  output logic [PTR_W-1:0]  wr_addr_o,
  output logic [ROWS-1:0]   wr_mask_o,
  output logic [ROWS-1:0]   wr_data_o
);

  logic             busy;
  logic [ROWS-1:0]  head;
  logic [CNT_W-1:0] take;
  mux_mode_e        mode_q;
  logic             bank_q;
  logic [PTR_W-1:0] ptr;
  logic [SUB_W-1:0] sub;

  dram_ld_seq #(
    .BYTE_W(BYTE_W), .ROWS(ROWS), .CNT_W(CNT_W)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .byte_valid_i(byte_valid_i),
    .byte_i      (byte_i),
    .mode_i      (mux_mode_e'(mode_i)),
    .bank_i      (bank_i),
    .busy_o      (busy),
    .head_o      (head),
    .take_o      (take),
    .mode_o      (mode_q),
    .bank_o      (bank_q)
  );

  dram_ld_ptr #(
    .DEPTH(DEPTH), .PTR_W(PTR_W), .SUB_W(SUB_W)
  ) u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (busy),
    .ld_ptr_i (ptr_load_i & ~busy),
    .ptr_val_i(ptr_val_i),
    .ld_sub_i (sub_load_i & ~busy),
    .sub_val_i(sub_val_i),
    .ptr_o    (ptr),
    .sub_o    (sub)
  );

  dram_ld_pack #(
    .ROWS(ROWS), .CNT_W(CNT_W)
  ) u_pack (
    .head_i(head),
    .take_i(take),
    .mode_i(mode_q),
    .bank_i(bank_q),
    .mask_o(wr_mask_o),
    .data_o(wr_data_o)
  );

  assign busy_o    = busy;
  assign wr_en_o   = busy & (sub == strap_i);
  assign wr_addr_o = ptr;

endmodule

// File: rtl/dram_ld_chk.sv
`timescale 1ns/1ps
module dram_ld_chk #(
  parameter int DEPTH = 24,
  parameter int ROWS  = 4,
  parameter int PTR_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_o,
  input logic             wr_en_o,
  input logic [PTR_W-1:0] wr_addr_o,
  input logic [ROWS-1:0]  wr_mask_o,
  input logic [1:0]       mode_q,
  input logic             bank_q
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  AST_WR_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> busy_o); // R8

  AST_ADDR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (wr_addr_o <= LAST)); // R9

  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |->
      (wr_addr_o == (($past(wr_addr_o) == LAST) ? '0 : $past(wr_addr_o) + 1'b1))); // R7

  AST_STATIC_ONE_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && mode_q == 2'd0) |-> ($countones(wr_mask_o) == 1)); // R2

  AST_TWO_ROWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && mode_q == 2'd1) |-> ($countones(wr_mask_o) == 2)); // R3

  AST_FOUR_ALL_ROWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && mode_q == 2'd3) |-> (wr_mask_o == {ROWS{1'b1}})); // R5

  AST_BANK_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && bank_q && mode_q[1] == 1'b0) |-> (wr_mask_o[1:0] == 2'b00)); // R6

endmodule

bind disp_ram_loader dram_ld_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .busy_o   (busy_o),
  .wr_en_o  (wr_en_o),
  .wr_addr_o(wr_addr_o),
  .wr_mask_o(wr_mask_o),
  .mode_q   (mode_q),
  .bank_q   (bank_q)
);

// File: tb/sim_disp_ram_loader.sv
`timescale 1ns/1ps
module sim_disp_ram_loader;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] byte_i = '0;
  logic       byte_valid_i = 1'b0;
  logic [1:0] mode_i = '0;
  logic       bank_i = 1'b0;
  logic       ptr_load_i = 1'b0;
  logic [4:0] ptr_val_i = '0;
  logic       sub_load_i = 1'b0;
  logic [2:0] sub_val_i = '0;
  logic [2:0] strap_i = '0;
  logic       busy_o, wr_en_o;
  logic [4:0] wr_addr_o;
  logic [3:0] wr_mask_o, wr_data_o;

  disp_ram_loader u0 (.*);

  always #2 clk_i = ~clk_i;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  logic [3:0] act_ram [24];
  logic [3:0] exp_ram [24];
  int m_ptr = 0;
  int m_sub = 0;

  // RAM image built from the write port
  always @(negedge clk_i) begin
    if (rst_ni && wr_en_o && wr_addr_o < 5'd24)
      for (int r = 0; r < 4; r++)
        if (wr_mask_o[r]) act_ram[wr_addr_o][r] = wr_data_o[r];
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic cmp_ram(input string tag);
    for (int a = 0; a < 24; a++)
      chk(act_ram[a] === exp_ram[a], tag, $sformatf("ram[%0d]", a), int'(act_ram[a]), int'(exp_ram[a]));
  endtask

  task automatic model_byte(input logic [7:0] b, input int mode, input bit bank);
    int k, n, off;
    k = mode + 1;
    n = (8 + k - 1) / k;
    off = (bank && mode < 2) ? 2 : 0;
    for (int i = 0; i < 8; i++) begin
      int a, s;
      a = m_ptr + i / k;
      s = m_sub;
      if (a >= 24) begin a -= 24; s = (s + 1) % 8; end
      if (s == int'(strap_i)) exp_ram[a][(i % k) + off] = b[7-i];
    end
    m_ptr += n;
    if (m_ptr >= 24) begin m_ptr -= 24; m_sub = (m_sub + 1) % 8; end
  endtask

  task automatic wait_idle();
    @(negedge clk_i);
    while (busy_o) @(negedge clk_i);
  endtask

  // issue one byte; optional same-cycle loads; returns busy length
  task automatic send(input logic [7:0] b, input int mode, input bit bank,
                      input bit lp, input int pv, input bit ls, input int sv,
                      output int blen);
    @(posedge clk_i); #1;
    byte_i = b; mode_i = 2'(mode); bank_i = bank; byte_valid_i = 1'b1;
    ptr_load_i = lp; ptr_val_i = 5'(pv); sub_load_i = ls; sub_val_i = 3'(sv);
    @(posedge clk_i); #1;
    byte_valid_i = 1'b0; ptr_load_i = 1'b0; sub_load_i = 1'b0;
    if (lp) m_ptr = (pv > 23) ? 0 : pv;
    if (ls) m_sub = sv;
    model_byte(b, mode, bank);
    blen = 0;
    @(negedge clk_i);
    while (busy_o) begin blen++; @(negedge clk_i); end
  endtask

  task automatic t_reset();
    int bl;
    @(negedge clk_i);
    chk(busy_o == 1'b0, "R1", "busy after reset", int'(busy_o), 0);
    chk(wr_en_o == 1'b0, "R1", "wr_en after reset", int'(wr_en_o), 0);
    send(8'hA5, 0, 0, 0, 0, 0, 0, bl);   // no load: lands at 0..7
    cmp_ram("R1");
  endtask

  task automatic t_modes();
    int bl;
    send(8'h3C, 0, 0, 1, 8, 0, 0, bl);
    chk(bl == 8, "R7", "static busy cycles", bl, 8);
    cmp_ram("R2");
    send(8'hB4, 1, 0, 1, 16, 0, 0, bl);
    chk(bl == 4, "R7", "two-way busy cycles", bl, 4);
    cmp_ram("R3");
    send(8'hFF, 3, 0, 1, 4, 0, 0, bl);   // preset rows for R4
    send(8'hFF, 3, 0, 0, 0, 0, 0, bl);
    chk(bl == 2, "R7", "four-way busy cycles", bl, 2);
    send(8'h00, 2, 0, 1, 4, 0, 0, bl);   // row 2 of address 6 stays 1
    chk(bl == 3, "R7", "three-way busy cycles", bl, 3);
    chk(act_ram[6][2] === 1'b1, "R4", "row2 kept", int'(act_ram[6][2]), 1);
    cmp_ram("R4");
    send(8'h96, 3, 0, 1, 20, 0, 0, bl);
    cmp_ram("R5");
  endtask

  task automatic t_bank();
    int bl;
    send(8'hC9, 0, 1, 1, 0, 0, 0, bl);
    send(8'h71, 1, 1, 0, 0, 0, 0, bl);
    send(8'h5A, 2, 1, 1, 12, 0, 0, bl);  // bank ignored here
    send(8'hE1, 3, 1, 0, 0, 0, 0, bl);
    cmp_ram("R6");
  endtask

  task automatic t_gate();
    int bl;
    int seen;
    send(8'hAA, 0, 0, 1, 0, 1, 2, bl);   // blocked
    cmp_ram("R8");
    send(8'h55, 0, 0, 0, 0, 1, 0, bl);   // pointer moved to 8 anyway
    cmp_ram("R8");
    // no write strobe at all while mismatched
    seen = 0;
    fork
      send(8'hFF, 3, 0, 1, 0, 1, 5, bl);
      begin
        repeat (5) begin @(negedge clk_i); if (wr_en_o) seen++; end
      end
    join
    chk(seen == 0, "R8", "wr_en while mismatched", seen, 0);
  endtask

  task automatic t_wrap();
    int bl;
    strap_i = 3'd1;
    send(8'hC3, 2, 0, 1, 22, 1, 0, bl);  // 22,23 blocked; 0 stored under sub 1
    cmp_ram("R9");
    send(8'h0F, 3, 0, 0, 0, 0, 0, bl);   // continues at 1, sub 1
    cmp_ram("R9");
    send(8'h81, 0, 0, 1, 20, 1, 1, bl);  // 20..23 kept, 0..3 go to sub 2
    cmp_ram("R9");
    strap_i = 3'd0;
  endtask

  task automatic t_busy_ignore();
    int bl;
    @(posedge clk_i); #1;
    byte_i = 8'h6D; mode_i = 2'd0; bank_i = 1'b0; byte_valid_i = 1'b1;
    ptr_load_i = 1'b1; ptr_val_i = 5'd8; sub_load_i = 1'b1; sub_val_i = 3'd0;
    @(posedge clk_i); #1;
    m_ptr = 8; m_sub = 0;
    model_byte(8'h6D, 0, 0);
    // strobes during busy: byte, pointer and subaddress loads
    byte_i = 8'hFF; mode_i = 2'd3; byte_valid_i = 1'b1;
    ptr_val_i = 5'd2; sub_val_i = 3'd6;
    repeat (3) @(posedge clk_i);
    #1;
    byte_valid_i = 1'b0; ptr_load_i = 1'b0; sub_load_i = 1'b0;
    bl = 3;
    @(negedge clk_i);
    while (busy_o) begin bl++; @(negedge clk_i); end
    chk(bl == 8, "R10", "busy length with strobes", bl, 8);
    cmp_ram("R10");
    send(8'h24, 1, 0, 0, 0, 0, 0, bl);   // must continue at 16, sub 0
    cmp_ram("R11");
  endtask

  task automatic t_same_cycle();
    int bl;
    send(8'h99, 3, 0, 1, 10, 1, 0, bl);
    cmp_ram("R11");
  endtask

  task automatic t_big_ptr();
    int bl;
    send(8'hD2, 3, 0, 1, 30, 1, 0, bl);  // clamps to 0
    cmp_ram("R12");
  endtask

  initial begin
    for (int a = 0; a < 24; a++) begin act_ram[a] = '0; exp_ram[a] = '0; end
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    t_reset();
    t_modes();
    t_bank();
    t_gate();
    t_wrap();
    t_busy_ignore();
    t_same_cycle();
    t_big_ptr();
    wait_idle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule